// File: doc/BRIEF.md
# Dual-Channel Serial Converter Interface Emulator

This block stands in for the digital side of a two-channel, simultaneous-sampling serial converter. A host drives an active-low select and a serial clock into the block. The block answers on one serial data line with a 32-clock frame that carries both channel results. A parallel source inside the system clock domain supplies the two 12-bit sample words. The block takes a snapshot of both words at one shared sampling instant, and that snapshot stands in for the analog conversion.

Select and the serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are found in the system clock domain. The block accepts all three ways a select falling edge can line up with the serial clock, and it counts frame edges to match. It runs back-to-back conversions while select stays low. When select rises, it drops the frame at once. The data line comes out as a value plus an enable, so that a pad or a wrapper can make it tri-state. A mode output reports power-down, acquisition or conversion.

Top module: `twinch_serial_emu`

## Requirements
- R1: While the synchronized select is high, `dout_en` is 0, `dout` is 0 and `mode` is 2'b00 (power-down). These are also the values after reset.
- R2: A falling edge on `sel_n` sets `dout_en` to 1, with `dout` driving 0 and `mode` at 2'b01 (acquisition).
- R3: If `sclk` is high when select falls, the next falling edge of `sclk` is frame edge 1.
- R4: If `sclk` is already low when select falls, the select edge itself counts as frame edge 1, and the next `sclk` falling edge is edge 2.
- R5: If select and `sclk` fall in the same synchronizer sample, the pair counts as a single frame edge 1.
- R6: Each frame edge k (1..32) drives one bit, which holds until the next falling edge. Edges 1-4 drive 0. Edges 5-16 drive channel A bits 11 down to 0. Edges 17-20 drive 0. Edges 21-32 drive channel B bits 11 down to 0.
- R7: Both `smp_a` and `smp_b` are captured at frame edge 4 of each conversion. Changes to the inputs after that edge do not alter the bits of that conversion.
- R8: `mode` is 2'b01 before frame edge 4 of a conversion and 2'b10 from edge 4 through edge 32.
- R9: While select stays low after edge 32, the next `sclk` falling edge starts a new conversion at edge 1 with `mode` 2'b01. The block samples again at edge 32·N+4 and sends the new values.
- R10: Select rising at any point, including before edge 16, ends the frame. The output floats (`dout_en` 0) and the block enters power-down. The next select fall starts a fresh frame aligned as in R3-R5.
- R11: An edge on `sel_n` or `sclk` reaches the outputs on the third system clock edge after the pin change is first sampled. The system clock must run at least 8 times faster than `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_a | input | 12 | Channel A parallel sample word (two's complement) |
| smp_b | input | 12 | Channel B parallel sample word (two's complement) |
| sel_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Drive enable for the serial data line; 0 means high-impedance |
| mode | output | 2 | 00 power-down, 01 acquisition, 10 conversion |

## Verification
The hardest situations to reach are the three alignments of the select edge against the serial clock. In the third case, both pins must fall within a single synchronizer sample. The bench reaches it by changing both pins on the same half-cycle of the system clock, well away from the sampling edge. It reaches the other two cases by parking `sclk` high or low several cycles before select falls. Continuous conversion and early abort are exercised as well. The inputs change between the sampling edge and the end of a frame, which shows that the latched words and not the live inputs are sent.

// File: rtl/twinch_pkg.sv
`timescale 1ns/1ps
package twinch_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_TRACK   = 2'b01,
    MODE_CONVERT = 2'b10
  } link_mode_t;
endpackage

// File: rtl/twinch_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with falling-edge detection in the system domain.
module twinch_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fell
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RESET_VAL}};
      last  <= RESET_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fell  = last & ~level;
endmodule

// File: rtl/twinch_frame_ctl.sv
`timescale 1ns/1ps
// Frame edge counter: select/clock alignment, wrap for continuous mode, mode.
module twinch_frame_ctl
  import twinch_pkg::*;
#(
  parameter int LEAD_W = 4,
  parameter int DATA_W = 12,
  localparam int FRAME_LEN = 2 * (LEAD_W + DATA_W),
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_lvl,
  input  logic          sel_fell,
  input  logic          sclk_lvl,
  input  logic          sclk_fell,
  output logic [CW-1:0] idx_nxt,
  output logic [CW-1:0] edge_idx,
  output logic          cap,
  output link_mode_t    mode
);
  localparam logic [CW-1:0] LAST_C = CW'(FRAME_LEN);
  localparam logic [CW-1:0] ONE_C  = CW'(1);
  localparam logic [CW-1:0] SAMP_C = CW'(LEAD_W);

  always_comb begin
    idx_nxt = edge_idx;
    cap     = 1'b0;
    if (sel_lvl) begin
      idx_nxt = '0;
    end else if (sel_fell) begin
      // clock low (or falling together) -> select edge is edge 1
      idx_nxt = sclk_lvl ? '0 : ONE_C;
    end else if (sclk_fell) begin
      idx_nxt = (edge_idx == LAST_C) ? ONE_C : edge_idx + ONE_C;
      cap     = (idx_nxt == SAMP_C);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_idx <= '0;
      mode     <= MODE_OFF;
    end else begin
      edge_idx <= idx_nxt;
      mode     <= sel_lvl ? MODE_OFF :
                  ((idx_nxt >= SAMP_C) ? MODE_CONVERT : MODE_TRACK);
    end
  end
endmodule

// File: rtl/twinch_word_out.sv
`timescale 1ns/1ps
// Holding registers for both channels and the serial bit picker.
module twinch_word_out #(
  parameter int LEAD_W = 4,
  parameter int DATA_W = 12,
  localparam int HALF = LEAD_W + DATA_W,
  localparam int CW = $clog2(2 * HALF + 1),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic              cap,
  input  logic              sel_lvl,
  input  logic [CW-1:0]     idx_nxt,
  output logic              dout
);
  localparam int NCH = 2;
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD_W);

  logic [DATA_W-1:0] live [NCH];
  logic [DATA_W-1:0] hold [NCH];

  assign live[0] = smp_a;
  assign live[1] = smp_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)      hold[ch] <= '0;
      else if (cap) hold[ch] <= live[ch];
    end
  end

  logic              second;
  logic [CW-1:0]     pos;
  logic [CW-1:0]     bidx;
  logic [DATA_W-1:0] word;
  logic              pick;

  always_comb begin
    second = (idx_nxt > HALF_C);
    pos    = second ? (idx_nxt - HALF_C) : idx_nxt;
    word   = second ? hold[1] : hold[0];
    bidx   = HALF_C - pos;
    pick   = (pos > LEAD_C) ? word[bidx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= ~sel_lvl & pick;
  end
endmodule

// File: rtl/twinch_serial_emu.sv
`timescale 1ns/1ps
module twinch_serial_emu
  import twinch_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic              sel_n,
  input  logic              sclk,
  output logic              dout,
  output logic              dout_en,
  output logic [1:0]        mode
);
  localparam int FRAME_LEN = 2 * (LEAD_W + DATA_W);
  localparam int CW        = $clog2(FRAME_LEN + 1);

  logic          sel_lvl, sel_fell, sclk_lvl, sclk_fell, cap;
  logic [CW-1:0] idx_nxt, edge_idx;
  link_mode_t    mode_q;

  twinch_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst(rst), .async_in(sel_n), .level(sel_lvl), .fell(sel_fell)
  );

  twinch_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .async_in(sclk), .level(sclk_lvl), .fell(sclk_fell)
  );

  twinch_frame_ctl #(.LEAD_W(LEAD_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst),
    .sel_lvl(sel_lvl), .sel_fell(sel_fell),
    .sclk_lvl(sclk_lvl), .sclk_fell(sclk_fell),
    .idx_nxt(idx_nxt), .edge_idx(edge_idx), .cap(cap), .mode(mode_q)
  );

  twinch_word_out #(.LEAD_W(LEAD_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .smp_a(smp_a), .smp_b(smp_b),
    .cap(cap), .sel_lvl(sel_lvl), .idx_nxt(idx_nxt), .dout(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= ~sel_lvl;
  end

  assign mode = mode_q;
endmodule

// File: rtl/twinch_serial_emu_chk.sv
`timescale 1ns/1ps
module twinch_serial_emu_chk #(
  parameter int LEAD_W = 4,
  parameter int DATA_W = 12,
  localparam int FRAME_LEN = 2 * (LEAD_W + DATA_W),
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_lvl,
  input logic          sel_fell,
  input logic          sclk_lvl,
  input logic          sclk_fell,
  input logic          cap,
  input logic [CW-1:0] edge_idx,
  input logic          dout,
  input logic          dout_en,
  input logic [1:0]    mode
);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == 1'b0 && mode == 2'b00));

  // R2
  sel_enable_chk: assert property (@(posedge clk) disable iff (rst)
    sel_fell |=> (dout_en && mode == 2'b01 && dout == 1'b0));

  // R3
  high_align_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_fell && sclk_lvl) |=> (edge_idx == '0));

  // R4
  low_align_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_fell && !sclk_lvl) |=> (edge_idx == CW'(1)));

  // R7
  sample_edge_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (edge_idx == CW'(LEAD_W) && mode == 2'b10));

  // R8
  convert_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_en && edge_idx >= CW'(LEAD_W)) |-> (mode == 2'b10));

  // R6
  lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (dout == 1'b0));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_fell && !sel_lvl && !sel_fell && edge_idx == CW'(FRAME_LEN))
      |=> (edge_idx == CW'(1) && mode == 2'b01));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    sel_lvl |=> (!dout_en && edge_idx == '0));
endmodule

bind twinch_serial_emu twinch_serial_emu_chk #(.LEAD_W(LEAD_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_lvl(sel_lvl), .sel_fell(sel_fell),
  .sclk_lvl(sclk_lvl), .sclk_fell(sclk_fell), .cap(cap), .edge_idx(edge_idx),
  .dout(dout), .dout_en(dout_en), .mode(mode)
);

// File: tb/twinch_serial_emu_test.sv
`timescale 1ns/1ps
module twinch_serial_emu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] smp_a = '0;
  logic [11:0] smp_b = '0;
  wire         dout, dout_en;
  wire  [1:0]  mode;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  twinch_serial_emu uut (
    .clk(clk), .rst(rst), .smp_a(smp_a), .smp_b(smp_b),
    .sel_n(sel_n), .sclk(sclk), .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_en = 1'b0;
  logic        m_dout = 1'b0;
  logic [1:0]  m_mode = 2'b00;
  int          m_cnt = 0;
  logic [11:0] m_ha = '0;
  logic [11:0] m_hb = '0;
  logic        sel_q[$]  = '{1'b1, 1'b1, 1'b1};
  logic        sclk_q[$] = '{1'b1, 1'b1, 1'b1};

  function automatic logic model_bit(input int k, input logic [11:0] a, input logic [11:0] b);
    if (k >= 5 && k <= 16)       return a[16-k];
    else if (k >= 21 && k <= 32) return b[32-k];
    else                         return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic sn, so, cn, co;
    if (rst) begin
      m_en = 1'b0; m_cnt = 0; m_ha = '0; m_hb = '0; m_mode = 2'b00; m_dout = 1'b0;
      sel_q  = '{1'b1, 1'b1, 1'b1};
      sclk_q = '{1'b1, 1'b1, 1'b1};
    end else begin
      sn = sel_q[1];  so = sel_q[2];
      cn = sclk_q[1]; co = sclk_q[2];
      if (sn) begin
        m_en = 1'b0; m_cnt = 0;
      end else if (so) begin
        m_en = 1'b1; m_cnt = cn ? 0 : 1;
      end else if (co && !cn) begin
        m_cnt = (m_cnt == 32) ? 1 : m_cnt + 1;
        if (m_cnt == 4) begin m_ha = smp_a; m_hb = smp_b; end
      end
      m_mode = !m_en ? 2'b00 : ((m_cnt >= 4) ? 2'b10 : 2'b01);
      m_dout = m_en ? model_bit(m_cnt, m_ha, m_hb) : 1'b0;
      sel_q.push_front(sel_n);  void'(sel_q.pop_back());
      sclk_q.push_front(sclk);  void'(sclk_q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 dout_en vs model", 32'(dout_en), 32'(m_en));
      chk("R8 mode vs model",    32'(mode),    32'(m_mode));
      chk("R6 dout vs model",    32'(dout),    32'(m_dout));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [11:0] a, input logic [11:0] b);
    return {4'b0000, a, 4'b0000, b};
  endfunction

  // align: 1 = clock high at select fall, 2 = clock low, 3 = fall together
  task automatic frame(input int align, input int nconv,
                       input logic [11:0] a0, input logic [11:0] b0,
                       input logic [11:0] a1, input logic [11:0] b1,
                       output logic [31:0] w0, output logic [31:0] w1,
                       output logic [1:0] m3, output logic [1:0] m4, output logic [1:0] m33);
    smp_a = a0; smp_b = b0;
    w0 = '0; w1 = '0; m3 = '0; m4 = '0; m33 = '0;
    sclk = (align == 2) ? 1'b0 : 1'b1;
    wt(4);
    sel_n = 1'b0;
    if (align == 3) sclk = 1'b0;
    if (align == 1) wt(4);
    for (int k = 1; k <= 32 * nconv; k++) begin
      if (!(k == 1 && align != 1)) sclk = 1'b0;
      wt(4);
      if (k <= 32) w0[32-k] = dout;
      else         w1[64-k] = dout;
      if (k == 3)  m3 = mode;
      if (k == 4)  m4 = mode;
      if (k == 33) m33 = mode;
      if (k == 8) begin smp_a = a1; smp_b = b1; end
      sclk = 1'b1;
      wt(4);
    end
    sel_n = 1'b1;
    wt(6);
  endtask

  task automatic abort_frame(input int nedges);
    sclk = 1'b1;
    wt(4);
    sel_n = 1'b0;
    wt(2);
    chk("R11 enable not yet visible", 32'(dout_en), 32'd0);
    wt(1);
    chk("R11 enable on third edge", 32'(dout_en), 32'd1);
    wt(1);
    for (int k = 1; k <= nedges; k++) begin
      sclk = 1'b0; wt(4);
      sclk = 1'b1; wt(4);
    end
    sel_n = 1'b1;
    wt(6);
    chk("R10 output floats after abort", 32'(dout_en), 32'd0);
    chk("R10 mode off after abort", 32'(mode), 32'd0);
  endtask

  initial begin
    logic [31:0] w0, w1;
    logic [1:0]  m3, m4, m33;
    wt(6);
    rst = 1'b0;
    wt(4);
    chk("R1 reset dout_en", 32'(dout_en), 32'd0);
    chk("R1 reset mode", 32'(mode), 32'd0);
    chk("R1 reset dout", 32'(dout), 32'd0);

    frame(1, 1, 12'hA5C, 12'h3E1, 12'h000, 12'hFFF, w0, w1, m3, m4, m33);
    chk("R3 R6 frame word clock-high alignment", w0, exp_word(12'hA5C, 12'h3E1));
    chk("R7 channel A held after input change", 32'(w0[27:16]), 32'h0A5C);
    chk("R8 mode at edge 3", 32'(m3), 32'd1);
    chk("R8 mode at edge 4", 32'(m4), 32'd2);
    chk("R1 idle after frame", 32'(dout_en), 32'd0);

    frame(2, 1, 12'h7FF, 12'h800, 12'h555, 12'h2AA, w0, w1, m3, m4, m33);
    chk("R4 frame word clock-low alignment", w0, exp_word(12'h7FF, 12'h800));

    frame(3, 1, 12'h001, 12'hFFE, 12'hFFF, 12'h000, w0, w1, m3, m4, m33);
    chk("R5 frame word simultaneous fall", w0, exp_word(12'h001, 12'hFFE));
    chk("R8 mode at edge 4 simultaneous", 32'(m4), 32'd2);

    frame(1, 2, 12'h123, 12'hABC, 12'hDEF, 12'h456, w0, w1, m3, m4, m33);
    chk("R7 first conversion keeps latched words", w0, exp_word(12'h123, 12'hABC));
    chk("R9 second conversion resamples", w1, exp_word(12'hDEF, 12'h456));
    chk("R9 mode back to acquisition at edge 33", 32'(m33), 32'd1);

    frame(3, 2, 12'hC3C, 12'h0F0, 12'h8A1, 12'h7E7, w0, w1, m3, m4, m33);
    chk("R9 continuous after simultaneous fall, conv 1", w0, exp_word(12'hC3C, 12'h0F0));
    chk("R9 continuous after simultaneous fall, conv 2", w1, exp_word(12'h8A1, 12'h7E7));

    abort_frame(10);
    frame(1, 1, 12'h9B6, 12'h14D, 12'h000, 12'h000, w0, w1, m3, m4, m33);
    chk("R10 fresh frame after abort", w0, exp_word(12'h9B6, 12'h14D));

    abort_frame(3);
    frame(2, 1, 12'h6E2, 12'hD19, 12'h111, 12'h222, w0, w1, m3, m4, m33);
    chk("R10 clock-low frame after early abort", w0, exp_word(12'h6E2, 12'hD19));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule